// File: doc/BRIEF.md
# Iterative Differential Equation Datapath

This block numerically integrates a second-order differential equation with a small multicycle datapath and a fixed-schedule controller. A job starts when `start_i` is high while `ready_o` is high. In that cycle the engine captures five signed operands: the state variables x, y and u, the step size dx and the bound a. It then runs an update iteration again and again. Each iteration advances x by dx, updates u and y from the current state, and compares x against the bound. When the loop exits, the final y is presented on `y_o` and `done_o` pulses for one cycle.

Each iteration has eleven operations: six multiplications and five ALU operations (one compare, two adds, two subtracts). They are time-multiplexed onto one ALU and either one or two multipliers, selected by `NUM_MUL`. The constant 3 is applied through the shared multiplier. Intermediate products and partial results are kept in registers between control steps. The three state variables are replaced together on the last step of an iteration. All arithmetic is W-bit two's complement and wraps around.

Top module: `diffeq_engine`

## Requirements
- R1: After reset, `ready_o` is 1 and `done_o` is 0.
- R2: A high `start_i` while `ready_o` is 1 loads x_i, y_i, u_i, dx_i and a_i, and `ready_o` is 0 from the next cycle until the job ends. A `start_i` or operand change while `ready_o` is 0 has no effect on the result.
- R3: Each iteration sets x to x + dx.
- R4: Each iteration sets u to u - 3·x·u·dx - 3·y·dx, using the values from the start of that iteration.
- R5: Each iteration sets y to y + u·dx. After the loop, `y_o` carries the final y.
- R6: Every job runs at least one iteration. The flag c = (x < a) is a signed comparison that uses x from the start of the iteration. The loop repeats while c is 1 and ends after the first iteration in which c is 0 (so x equal to a ends it).
- R7: `done_o` is high for exactly one cycle, with the final y on `y_o` in that cycle, and `ready_o` is 1 in the following cycle.
- R8: An iteration takes 5 cycles with `NUM_MUL` = 2 and 7 cycles with `NUM_MUL` = 1. For N iterations, `done_o` is first seen high N·steps clock edges after the edge that accepted the start. No multiplier is given two operations in one step, and no product is read in the step that writes it.
- R9: All arithmetic wraps modulo 2^W, including products of large operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when ready_o is 1 |
| x_i | input | W | Initial x (signed) |
| y_i | input | W | Initial y (signed) |
| u_i | input | W | Initial u (signed) |
| dx_i | input | W | Step size (signed) |
| a_i | input | W | Loop bound for x (signed) |
| ready_o | output | 1 | Idle and able to take a start |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| y_o | output | W | Current y; the final result when done_o is 1 |

## Verification
Both schedules (one and two multipliers) run side by side on the same jobs. The results are compared with a cycle-free model of the recurrence, for both y and the cycles to completion.

Directed jobs cover these cases:
- A bound below x and a bound equal to x: both give exactly one iteration, which separates `<` from `<=`.
- A two-iteration case: checks that the compare uses the pre-update x.
- A negative x with a positive bound: tells a signed compare from an unsigned one.
- Large u and y: force wrap-around in the products.
- A start pulse with altered operands in the middle of a job: must leave the result unchanged.

Random jobs limited to 64 iterations then exercise the general recurrence.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;

  // multiplier operations; value-1 is the product register index
  typedef enum logic [2:0] {
    MOP_NONE  = 3'd0,
    MOP_3X    = 3'd1,  // p0 = 3*x
    MOP_UDX_A = 3'd2,  // p1 = u*dx
    MOP_P0P1  = 3'd3,  // p2 = p0*p1
    MOP_3Y    = 3'd4,  // p3 = 3*y
    MOP_P3DX  = 3'd5,  // p4 = p3*dx
    MOP_UDX_B = 3'd6   // p5 = u*dx
  } mop_e;

  typedef enum logic [2:0] {
    AOP_NONE,
    AOP_CMP,    // c  = x < a
    AOP_XADD,   // xn = x + dx
    AOP_SUB_A,  // s1 = u - p2
    AOP_SUB_B,  // un = s1 - p4
    AOP_YADD    // y  = y + p5 (commit step)
  } aop_e;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_LT} alu_fn_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  localparam int NUM_PROD = 6;

  function automatic int steps_for(int num_mul);
    return (num_mul >= 2) ? 5 : 7;
  endfunction

endpackage

// File: rtl/diffeq_mul_lane.sv
module diffeq_mul_lane
  import diffeq_pkg::*;
#(
  parameter int W = 16
) (
  input  mop_e         op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] dx_i,
  input  logic [W-1:0] p0_i,
  input  logic [W-1:0] p1_i,
  input  logic [W-1:0] p3_i,
  output logic [W-1:0] prod_o
);

  localparam logic [W-1:0] K3 = W'(3);

  logic [W-1:0] opa, opb;

  always_comb begin
    opa = '0;
    opb = '0;
    case (op_i)
      MOP_3X:               begin opa = K3;   opb = x_i;  end
      MOP_UDX_A, MOP_UDX_B: begin opa = u_i;  opb = dx_i; end
      MOP_P0P1:             begin opa = p0_i; opb = p1_i; end
      MOP_3Y:               begin opa = K3;   opb = y_i;  end
      MOP_P3DX:             begin opa = p3_i; opb = dx_i; end
      default: ;
    endcase
  end

  // low W bits are identical for signed and unsigned operands
  assign prod_o = opa * opb;

endmodule

// File: rtl/diffeq_alu.sv
module diffeq_alu
  import diffeq_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_fn_e      fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);

  always_comb begin
    case (fn_i)
      FN_ADD:  r_o = a_i + b_i;
      FN_SUB:  r_o = a_i - b_i;
      FN_LT:   r_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: r_o = '0;
    endcase
  end

endmodule

// File: rtl/diffeq_ctrl.sv
module diffeq_ctrl
  import diffeq_pkg::*;
#(
  parameter int NUM_MUL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic c_i,
  output logic ready_o,
  output logic done_o,
  output logic load_o,
  output logic commit_o,
  output mop_e mul_op_o [NUM_MUL],
  output aop_e alu_op_o
);

  localparam int STEPS = steps_for(NUM_MUL);
  localparam int SW    = $clog2(STEPS);

  st_e           st_q;
  logic [SW-1:0] step_q;
  logic          last;

  assign ready_o  = (st_q == ST_IDLE);
  assign done_o   = (st_q == ST_DONE);
  assign load_o   = ready_o && start_i;
  assign last     = (st_q == ST_RUN) && (step_q == SW'(STEPS - 1));
  assign commit_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          step_q <= '0;
        end
        ST_RUN: begin
          if (last) begin
            step_q <= '0;
            st_q   <= c_i ? ST_RUN : ST_DONE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // static schedules; products are read no earlier than the step after they are written
  generate
    if (NUM_MUL >= 2) begin : g_sched_two
      always_comb begin
        for (int l = 0; l < NUM_MUL; l++) mul_op_o[l] = MOP_NONE;
        alu_op_o = AOP_NONE;
        if (st_q == ST_RUN) begin
          case (int'(step_q))
            0: begin mul_op_o[0] = MOP_3X;   mul_op_o[1] = MOP_UDX_A; alu_op_o = AOP_CMP;   end
            1: begin mul_op_o[0] = MOP_P0P1; mul_op_o[1] = MOP_3Y;    alu_op_o = AOP_XADD;  end
            2: begin mul_op_o[0] = MOP_P3DX; mul_op_o[1] = MOP_UDX_B; alu_op_o = AOP_SUB_A; end
            3: alu_op_o = AOP_SUB_B;
            4: alu_op_o = AOP_YADD;
            default: ;
          endcase
        end
      end
    end else begin : g_sched_one
      always_comb begin
        mul_op_o[0] = MOP_NONE;
        alu_op_o    = AOP_NONE;
        if (st_q == ST_RUN) begin
          case (int'(step_q))
            0: begin mul_op_o[0] = MOP_3X;    alu_op_o = AOP_CMP;   end
            1: begin mul_op_o[0] = MOP_UDX_A; alu_op_o = AOP_XADD;  end
            2: mul_op_o[0] = MOP_3Y;
            3: mul_op_o[0] = MOP_P0P1;
            4: begin mul_op_o[0] = MOP_P3DX;  alu_op_o = AOP_SUB_A; end
            5: begin mul_op_o[0] = MOP_UDX_B; alu_op_o = AOP_SUB_B; end
            6: alu_op_o = AOP_YADD;
            default: ;
          endcase
        end
      end
    end
  endgenerate

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R7
  AST_DONE_TO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o) else $error("not ready after done"); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !ready_o) else $error("ready after accepted start"); // R2
  AST_EXIT_ON_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !c_i) else $error("loop left with c set"); // R6

endmodule

// File: rtl/diffeq_dpath.sv
module diffeq_dpath
  import diffeq_pkg::*;
#(
  parameter int W       = 16,
  parameter int NUM_MUL = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         commit_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] dx_i,
  input  logic [W-1:0] a_i,
  input  mop_e         mul_op_i [NUM_MUL],
  input  aop_e         alu_op_i,
  output logic         c_o,
  output logic [W-1:0] y_o
);

  logic [W-1:0] x_q, y_q, u_q, dx_q, a_q;
  logic [W-1:0] xn_q, un_q, s1_q;
  logic         c_q;
  logic [NUM_PROD-1:0][W-1:0] p_q;

  logic [W-1:0] prod [NUM_MUL];
  logic [NUM_PROD-1:0]        p_we;
  logic [NUM_PROD-1:0][W-1:0] p_wd;

  alu_fn_e      alu_fn;
  logic [W-1:0] alu_a, alu_b, alu_r;

  for (genvar l = 0; l < NUM_MUL; l++) begin : g_lane
    diffeq_mul_lane #(.W(W)) u_lane (
      .op_i  (mul_op_i[l]),
      .x_i   (x_q),
      .y_i   (y_q),
      .u_i   (u_q),
      .dx_i  (dx_q),
      .p0_i  (p_q[0]),
      .p1_i  (p_q[1]),
      .p3_i  (p_q[3]),
      .prod_o(prod[l])
    );
  end

  always_comb begin
    p_we = '0;
    p_wd = '0;
    for (int k = 0; k < NUM_PROD; k++) begin
      for (int l = 0; l < NUM_MUL; l++) begin
        if (mul_op_i[l] == mop_e'(3'(k + 1))) begin
          p_we[k] = 1'b1;
          p_wd[k] = prod[l];
        end
      end
    end
  end

  always_comb begin
    alu_fn = FN_ADD;
    alu_a  = '0;
    alu_b  = '0;
    case (alu_op_i)
      AOP_CMP:   begin alu_fn = FN_LT;  alu_a = x_q;  alu_b = a_q;    end
      AOP_XADD:  begin alu_fn = FN_ADD; alu_a = x_q;  alu_b = dx_q;   end
      AOP_SUB_A: begin alu_fn = FN_SUB; alu_a = u_q;  alu_b = p_q[2]; end
      AOP_SUB_B: begin alu_fn = FN_SUB; alu_a = s1_q; alu_b = p_q[4]; end
      AOP_YADD:  begin alu_fn = FN_ADD; alu_a = y_q;  alu_b = p_q[5]; end
      default: ;
    endcase
  end

  diffeq_alu #(.W(W)) u_alu (
    .fn_i(alu_fn),
    .a_i (alu_a),
    .b_i (alu_b),
    .r_o (alu_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      y_q  <= '0;
      u_q  <= '0;
      dx_q <= '0;
      a_q  <= '0;
      xn_q <= '0;
      un_q <= '0;
      s1_q <= '0;
      c_q  <= 1'b0;
      p_q  <= '0;
    end else begin
      if (load_i) begin
        x_q  <= x_i;
        y_q  <= y_i;
        u_q  <= u_i;
        dx_q <= dx_i;
        a_q  <= a_i;
      end else if (commit_i) begin
        x_q <= xn_q;
        u_q <= un_q;
        y_q <= alu_r;
      end
      for (int k = 0; k < NUM_PROD; k++) begin
        if (p_we[k]) p_q[k] <= p_wd[k];
      end
      case (alu_op_i)
        AOP_CMP:   c_q  <= alu_r[0];
        AOP_XADD:  xn_q <= alu_r;
        AOP_SUB_A: s1_q <= alu_r;
        AOP_SUB_B: un_q <= alu_r;
        default: ;
      endcase
    end
  end

  assign c_o = c_q;
  assign y_o = y_q;

  AST_COMMIT_YADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> alu_op_i == AOP_YADD) else $error("commit without y add"); // R5
  AST_SUB_A_DEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_op_i == AOP_SUB_A |-> !p_we[2]) else $error("p2 read while written"); // R8
  AST_SUB_B_DEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_op_i == AOP_SUB_B |-> !p_we[4]) else $error("p4 read while written"); // R8
  AST_YADD_DEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_op_i == AOP_YADD |-> !p_we[5]) else $error("p5 read while written"); // R8

  if (NUM_MUL >= 2) begin : g_uniq
    AST_MUL_DEST_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mul_op_i[0] == MOP_NONE || mul_op_i[0] != mul_op_i[1])
      else $error("two lanes on one product"); // R8
  end

endmodule

// File: rtl/diffeq_engine.sv
module diffeq_engine
  import diffeq_pkg::*;
#(
  parameter int W       = 16,
  parameter int NUM_MUL = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] dx_i,
  input  logic [W-1:0] a_i,
  output logic         ready_o,
  output logic         done_o,
  output logic [W-1:0] y_o
);

  mop_e mul_op [NUM_MUL];
  aop_e alu_op;
  logic load, commit, c_flag;

  diffeq_ctrl #(.NUM_MUL(NUM_MUL)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .c_i     (c_flag),
    .ready_o (ready_o),
    .done_o  (done_o),
    .load_o  (load),
    .commit_o(commit),
    .mul_op_o(mul_op),
    .alu_op_o(alu_op)
  );

  diffeq_dpath #(.W(W), .NUM_MUL(NUM_MUL)) u_dpath (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .commit_i(commit),
    .x_i     (x_i),
    .y_i     (y_i),
    .u_i     (u_i),
    .dx_i    (dx_i),
    .a_i     (a_i),
    .mul_op_i(mul_op),
    .alu_op_i(alu_op),
    .c_o     (c_flag),
    .y_o     (y_o)
  );

endmodule

// File: tb/tb_diffeq_engine.sv
`timescale 1ns/1ps
module tb_diffeq_engine;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x = '0, y = '0, u = '0, dx = '0, a = '0;
  logic         rdy2, done2, rdy1, done1;
  logic [W-1:0] yo2, yo1;

  diffeq_engine #(.W(W), .NUM_MUL(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_i(x), .y_i(y), .u_i(u), .dx_i(dx), .a_i(a),
    .ready_o(rdy2), .done_o(done2), .y_o(yo2));

  diffeq_engine #(.W(W), .NUM_MUL(1)) dut_m1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_i(x), .y_i(y), .u_i(u), .dx_i(dx), .a_i(a),
    .ready_o(rdy1), .done_o(done1), .y_o(yo1));

  typedef struct {logic [W-1:0] y; int iters;} exp_t;
  exp_t q2[$], q1[$];

  int errors = 0, checks = 0;
  int lat2 = 0, lat1 = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void ref_model(input logic [W-1:0] x0, y0, u0, dx0, a0,
                                    output logic [W-1:0] yf, output int n);
    logic signed [W-1:0] xs, ys, us, ds, av, xn, un, yn;
    bit c;
    xs = x0; ys = y0; us = u0; ds = dx0; av = a0; n = 0;
    do begin
      c  = (xs < av);
      xn = xs + ds;
      un = us - 3 * xs * us * ds - 3 * ys * ds;
      yn = ys + us * ds;
      xs = xn; us = un; ys = yn;
      n++;
    end while (c && n < 1000);
    yf = ys;
  endfunction

  // cycles since the accepting edge
  always @(posedge clk) begin
    if (start && rdy2) lat2 <= 0; else lat2 <= lat2 + 1;
    if (start && rdy1) lat1 <= 0; else lat1 <= lat1 + 1;
  end

  // monitors: scoreboard pop and compare
  always begin
    exp_t e;
    @(negedge clk);
    if (rst_n && done2) begin
      if (q2.size() == 0) check(1'b0, "R7", "m2 done with no job", 1, 0);
      else begin
        e = q2.pop_front();
        check(yo2 == e.y, "R3,R4,R5,R6,R9", "m2 final y",
              longint'($signed(yo2)), longint'($signed(e.y)));
        check(lat2 == e.iters * 5, "R8", "m2 latency", lat2, e.iters * 5);
      end
      @(negedge clk);
      check(!done2, "R7", "m2 done width", done2, 0);
      check(rdy2, "R7", "m2 ready after done", rdy2, 1);
    end
  end

  always begin
    exp_t e;
    @(negedge clk);
    if (rst_n && done1) begin
      if (q1.size() == 0) check(1'b0, "R7", "m1 done with no job", 1, 0);
      else begin
        e = q1.pop_front();
        check(yo1 == e.y, "R3,R4,R5,R6,R9", "m1 final y",
              longint'($signed(yo1)), longint'($signed(e.y)));
        check(lat1 == e.iters * 7, "R8", "m1 latency", lat1, e.iters * 7);
      end
      @(negedge clk);
      check(!done1, "R7", "m1 done width", done1, 0);
      check(rdy1, "R7", "m1 ready after done", rdy1, 1);
    end
  end

  task automatic run_job(input logic [W-1:0] xv, yv, uv, dxv, av, input bit poke);
    exp_t e;
    ref_model(xv, yv, uv, dxv, av, e.y, e.iters);
    while (!(rdy2 && rdy1)) @(negedge clk);
    q2.push_back(e);
    q1.push_back(e);
    x = xv; y = yv; u = uv; dx = dxv; a = av;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!rdy2, "R2", "m2 busy after start", rdy2, 0);
    check(!rdy1, "R2", "m1 busy after start", rdy1, 0);
    if (poke) begin
      // R2: start while busy must be ignored
      @(negedge clk);
      @(negedge clk);
      x = ~xv; y = 16'h1234; u = 16'h0101; dx = 16'd1; a = 16'h7fff;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q2.size() != 0 || q1.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog expired: actual=150000 expected=<150000");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdy2 == 1'b1 && done2 == 1'b0, "R1", "m2 reset state", {rdy2, done2}, 2);
    check(rdy1 == 1'b1 && done1 == 1'b0, "R1", "m1 reset state", {rdy1, done1}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_job(16'd10, 16'd7, 16'd3, 16'd2, 16'd5, 1'b0);        // R6 a<x: one iteration
    run_job(16'd5, 16'd9, 16'd4, 16'd1, 16'd5, 1'b0);         // R6 a==x: one iteration
    run_job(16'd0, 16'd2, 16'd5, 16'd1, 16'd1, 1'b0);         // R6 two iterations
    run_job(16'hFFEC, 16'd11, 16'hFFF0, 16'd3, 16'd10, 1'b0); // R6 signed compare
    run_job(16'd100, 16'h6000, 16'h7000, 16'd5, 16'd110, 1'b0); // R9 wrap
    run_job(16'd1, 16'd3, 16'd2, 16'd2, 16'd9, 1'b1);         // R2 start while busy

    for (int i = 0; i < 10; i++) begin
      int xv, dv, k;
      xv = $urandom_range(400) - 200;
      dv = $urandom_range(15, 1);
      k  = $urandom_range(60);
      run_job(W'(xv), W'($urandom), W'($urandom), W'(dv),
              W'(xv + dv * k - int'($urandom_range(3))), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule